// File: doc/BRIEF.md
# Shared PHY Power Sequencer

This block brings a multi-lane PHY up and down on behalf of several lane owners. Each lane has a power-on and a power-off request line. The block keeps a count of the lanes that are currently powered, so the shared PHY only goes through its reset release and PLL bring-up for the first user. The PHY reset is asserted again only when the last user leaves. Other power-on requests just take their lane out of idle. A power-off request puts its lane back into idle.

The bring-up is a fixed series of steps:

1. Release the PHY reset.
2. Point the indirect configuration port at the PLL register.
3. Wake the requesting lane.
4. Wait for PLL lock.
5. Issue two strobed configuration writes.
6. Wait for the PLL output-pending flag to clear.
7. Point the port at the PLL register again.
8. Wait for the PLL to lock a second time.

All three waits draw on one timeout budget that starts with the bring-up. The status flags are sampled only at poll points. When the budget runs out, the block puts the PHY back into reset, returns the lane to idle, undoes the count increment and answers with an error.

Requests are served one at a time, and only when the sequencer is idle. The answer to each request is a one-cycle done or error pulse on the requesting lane's bit. The requester holds its request until it sees that pulse, then drops it.

States:

| State | Role |
|---|---|
| `S_IDLE` | Waits for a request. |
| `S_BR_RST` | Releases the PHY reset. |
| `S_BR_SEL` | Points the configuration port at the PLL register. |
| `S_BR_LANE` | Wakes the requesting lane. |
| `S_BR_WLOCK` | First lock wait. |
| `S_BR_W1A` | Sets up the first write. |
| `S_BR_W1S` | Strobes the first write. |
| `S_BR_W2A` | Sets up the second write. |
| `S_BR_W2S` | Strobes the second write. |
| `S_BR_WOUT` | Waits for the output-pending flag to clear. |
| `S_BR_RESEL` | Points the port at the PLL register again. |
| `S_BR_WRELOCK` | Second lock wait. |
| `S_FAIL` | Rollback after a timeout. |
| `S_JOIN` | Adds a user to an already powered PHY. |
| `S_LEAVE` | Removes a user. |
| `S_RESP` | Pulses done or error. |

Transitions out of `S_IDLE`:

| Request | Count | Next state |
|---|---|---|
| Power-on | zero | `S_BR_RST` |
| Power-on | non-zero | `S_JOIN` |
| Power-off | non-zero | `S_LEAVE` |
| Power-off | zero | `S_RESP`, with an error |

Other transitions:

- Each bring-up state moves to the next one in the list above.
- A wait state advances when its flag is seen at a poll point.
- A wait state goes to `S_FAIL` once the budget has expired.
- `S_FAIL`, `S_JOIN` and `S_LEAVE` go to `S_RESP`.
- `S_RESP` always goes to `S_IDLE`.

Top module: `phy_pwr_seq`

## Requirements
- R1: During and after reset the outputs read as follows: `phy_rst`=1, every `lane_idle` bit 1, `user_cnt`=0, `cfg_wr`=0, and no done or error pulse.
- R2: An idle sequencer serves the lowest-numbered lane that has any request. Within one lane, power-on wins over power-off. Other requests wait until the sequencer is idle again.
- R3: A power-on with `user_cnt`=0 starts a bring-up. By the first cycle of the lock wait, 4 cycles after acceptance, three things hold: `phy_rst` is 0, `cfg_addr` is 0x10 and the requester's `lane_idle` bit is 0.
- R4: After the first lock, two writes follow, each with a one-cycle `cfg_wr` strobe. The first uses address 0x10 with data 0x8. The second uses address 0x12 with data 0x8. No other write is issued.
- R5: After the writes, the block waits for `pll_out_pending`=0. It then sets `cfg_addr` back to 0x10, waits for `pll_locked`=1 and pulses done. When both flags are already good, done arrives 12 cycles after the request is raised, and `user_cnt` becomes 1.
- R6: Flags are sampled only on the first cycle of each wait and every POLL_CYC cycles after that. A lock that rises 2 cycles into the first wait is seen POLL_CYC cycles into it, so done arrives at 12+POLL_CYC cycles.
- R7: The timeout budget counts TIMEOUT_CYC cycles from the first bring-up cycle. If it expires in any of the three waits, the error pulse arrives TIMEOUT_CYC+3 cycles after the request. At that point `phy_rst` is 1, `user_cnt` is back to 0 and every `lane_idle` bit is 1.
- R8: A power-on with `user_cnt`>0 issues no write. It clears the lane's idle bit, adds one to `user_cnt` and pulses done 2 cycles after the request.
- R9: A power-off with `user_cnt`>0 sets the lane's idle bit, subtracts one from `user_cnt` and pulses done 2 cycles after the request. `phy_rst` goes to 1 only when `user_cnt` reaches 0.
- R10: A power-off with `user_cnt`=0 changes nothing and pulses error 1 cycle after the request.
- R11: `user_cnt` never exceeds NUM_LANES. A power-on at that value still clears the lane's idle bit and pulses done, and the count is unchanged.
- R12: Done and error are single-cycle pulses. Each appears only on the bit of the lane being served, and the two never appear together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| on_req | input | NUM_LANES | Per-lane power-on request, held until answered |
| off_req | input | NUM_LANES | Per-lane power-off request, held until answered |
| pll_locked | input | 1 | PLL lock flag from the PHY |
| pll_out_pending | input | 1 | PLL output-enable pending flag from the PHY (1 = not yet enabled) |
| done | output | NUM_LANES | One-cycle success pulse on the served lane |
| err | output | NUM_LANES | One-cycle failure pulse on the served lane |
| phy_rst | output | 1 | PHY reset, 1 = held in reset |
| lane_idle | output | NUM_LANES | Per-lane idle control, 1 = lane idle |
| cfg_addr | output | CFG_AW | Indirect configuration address |
| cfg_data | output | CFG_DW | Indirect configuration write data |
| cfg_wr | output | 1 | One-cycle configuration write strobe |
| user_cnt | output | $clog2(NUM_LANES+1) | Number of powered users |

## Verification
A count that drifts shows up at the ports no later than the next request. A join then runs the full write sequence, or a leave fails to reach reset. An unneeded bring-up shifts the done pulse from 2 cycles to 12. The timer is checked by exact pulse latencies. A budget or poll point that is off by one moves the done or error pulse by a cycle, or by a whole poll interval, within a single request. Arbitration and rollback faults appear in which lane's bit pulses, and in the `lane_idle` and `phy_rst` values read right after the pulse.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_BR_RST,
        S_BR_SEL,
        S_BR_LANE,
        S_BR_WLOCK,
        S_BR_W1A,
        S_BR_W1S,
        S_BR_W2A,
        S_BR_W2S,
        S_BR_WOUT,
        S_BR_RESEL,
        S_BR_WRELOCK,
        S_FAIL,
        S_JOIN,
        S_LEAVE,
        S_RESP
    } seq_state_t;

    // configuration-port constants used by the bring-up
    localparam int PLL_REG_ADDR  = 'h10;
    localparam int CLK_REG_ADDR  = 'h12;
    localparam int RATE_SEL_DATA = 'h8;

endpackage

// File: rtl/lane_arb.sv
module lane_arb #(
    parameter int NUM_LANES = 4,
    localparam int LW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] on_req,
    input  logic [NUM_LANES-1:0] off_req,
    output logic                 gnt_valid,
    output logic [LW-1:0]        gnt_lane,
    output logic                 gnt_on
);

    // lowest index wins; scan from the top so the lowest overwrites last
    always_comb begin
        gnt_valid = 1'b0;
        gnt_lane  = '0;
        gnt_on    = 1'b0;
        for (int i = NUM_LANES - 1; i >= 0; i--) begin
            if (on_req[i] || off_req[i]) begin
                gnt_valid = 1'b1;
                gnt_lane  = LW'(i);
                gnt_on    = on_req[i];
            end
        end
    end

    AST_ARB_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ((on_req[gnt_lane] || off_req[gnt_lane]) &&
                       (gnt_on == on_req[gnt_lane]))) // R2
        else $error("grant to a lane without request");

endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int TIMEOUT_CYC = 1000,
    parameter int POLL_CYC    = 20,
    localparam int BW = $clog2(TIMEOUT_CYC + 1),
    localparam int PW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic budget_start,
    input  logic poll_restart,
    output logic poll_hit,
    output logic expired
);

    logic [BW-1:0] budget_cnt;
    logic [PW-1:0] poll_cnt;

    assign expired  = (budget_cnt == BW'(TIMEOUT_CYC));
    assign poll_hit = (poll_cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            budget_cnt <= '0;
        end else if (budget_start) begin
            budget_cnt <= '0;
        end else if (!expired) begin
            budget_cnt <= budget_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || poll_restart) begin
            poll_cnt <= '0;
        end else if (poll_cnt == PW'(POLL_CYC - 1)) begin
            poll_cnt <= '0;
        end else begin
            poll_cnt <= poll_cnt + 1'b1;
        end
    end

    AST_BUDGET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !budget_start) |=> expired) // R7
        else $error("budget expiry not held");

    AST_POLL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(poll_cnt) < POLL_CYC)) // R6
        else $error("poll counter out of range");

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
    import phy_pwr_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int TIMEOUT_CYC = 1000,
    parameter int POLL_CYC    = 20,
    parameter int CFG_AW      = 6,
    parameter int CFG_DW      = 4,
    localparam int LW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    localparam int CW = $clog2(NUM_LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] on_req,
    input  logic [NUM_LANES-1:0] off_req,
    input  logic                 pll_locked,
    input  logic                 pll_out_pending,
    output logic [NUM_LANES-1:0] done,
    output logic [NUM_LANES-1:0] err,
    output logic                 phy_rst,
    output logic [NUM_LANES-1:0] lane_idle,
    output logic [CFG_AW-1:0]    cfg_addr,
    output logic [CFG_DW-1:0]    cfg_data,
    output logic                 cfg_wr,
    output logic [CW-1:0]        user_cnt
);

    localparam logic [CFG_AW-1:0] ADDR_PLL = CFG_AW'(PLL_REG_ADDR);
    localparam logic [CFG_AW-1:0] ADDR_CLK = CFG_AW'(CLK_REG_ADDR);
    localparam logic [CFG_DW-1:0] DATA_SEL = CFG_DW'(RATE_SEL_DATA);
    localparam logic [CW-1:0]     CNT_MAX  = CW'(NUM_LANES);

    seq_state_t state, nstate;

    logic          gnt_valid, gnt_on;
    logic [LW-1:0] gnt_lane;
    logic [LW-1:0] cur_lane;
    logic          resp_err;
    logic          budget_start, poll_restart, poll_hit, expired;

    lane_arb #(.NUM_LANES(NUM_LANES)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .on_req    (on_req),
        .off_req   (off_req),
        .gnt_valid (gnt_valid),
        .gnt_lane  (gnt_lane),
        .gnt_on    (gnt_on)
    );

    seq_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .POLL_CYC(POLL_CYC)) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .budget_start (budget_start),
        .poll_restart (poll_restart),
        .poll_hit     (poll_hit),
        .expired      (expired)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: begin
                if (gnt_valid) begin
                    if (gnt_on) nstate = (user_cnt == '0) ? S_BR_RST : S_JOIN;
                    else        nstate = (user_cnt == '0) ? S_RESP : S_LEAVE;
                end
            end
            S_BR_RST:   nstate = S_BR_SEL;
            S_BR_SEL:   nstate = S_BR_LANE;
            S_BR_LANE:  nstate = S_BR_WLOCK;
            S_BR_WLOCK: begin
                if (poll_hit && pll_locked) nstate = S_BR_W1A;
                else if (expired)           nstate = S_FAIL;
            end
            S_BR_W1A:   nstate = S_BR_W1S;
            S_BR_W1S:   nstate = S_BR_W2A;
            S_BR_W2A:   nstate = S_BR_W2S;
            S_BR_W2S:   nstate = S_BR_WOUT;
            S_BR_WOUT: begin
                if (poll_hit && !pll_out_pending) nstate = S_BR_RESEL;
                else if (expired)                 nstate = S_FAIL;
            end
            S_BR_RESEL: nstate = S_BR_WRELOCK;
            S_BR_WRELOCK: begin
                if (poll_hit && pll_locked) nstate = S_RESP;
                else if (expired)           nstate = S_FAIL;
            end
            S_FAIL:     nstate = S_RESP;
            S_JOIN:     nstate = S_RESP;
            S_LEAVE:    nstate = S_RESP;
            S_RESP:     nstate = S_IDLE;
            default:    nstate = S_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        cfg_wr       = 1'b0;
        done         = '0;
        err          = '0;
        budget_start = 1'b0;
        poll_restart = 1'b0;
        unique case (state)
            S_IDLE:     budget_start = 1'b1;
            S_BR_LANE,
            S_BR_W2S,
            S_BR_RESEL: begin
                poll_restart = 1'b1;
                cfg_wr       = (state == S_BR_W2S);
            end
            S_BR_W1S:   cfg_wr = 1'b1;
            S_RESP: begin
                if (resp_err) err[cur_lane]  = 1'b1;
                else          done[cur_lane] = 1'b1;
            end
            default: ;
        endcase
    end

    // held controls and the user count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_rst   <= 1'b1;
            lane_idle <= '1;
            cfg_addr  <= '0;
            cfg_data  <= '0;
            user_cnt  <= '0;
            cur_lane  <= '0;
            resp_err  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (gnt_valid) begin
                        cur_lane <= gnt_lane;
                        resp_err <= !gnt_on && (user_cnt == '0);
                        if (gnt_on && user_cnt != CNT_MAX) user_cnt <= user_cnt + 1'b1;
                    end
                end
                S_BR_RST:   phy_rst <= 1'b0;
                S_BR_SEL:   cfg_addr <= ADDR_PLL;
                S_BR_LANE:  lane_idle[cur_lane] <= 1'b0;
                S_BR_W1A: begin
                    cfg_addr <= ADDR_PLL;
                    cfg_data <= DATA_SEL;
                end
                S_BR_W2A: begin
                    cfg_addr <= ADDR_CLK;
                    cfg_data <= DATA_SEL;
                end
                S_BR_RESEL: cfg_addr <= ADDR_PLL;
                S_FAIL: begin
                    phy_rst             <= 1'b1;
                    lane_idle[cur_lane] <= 1'b1;
                    user_cnt            <= user_cnt - 1'b1;
                    resp_err            <= 1'b1;
                end
                S_JOIN:     lane_idle[cur_lane] <= 1'b0;
                S_LEAVE: begin
                    lane_idle[cur_lane] <= 1'b1;
                    user_cnt            <= user_cnt - 1'b1;
                    if (user_cnt == CW'(1)) phy_rst <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        user_cnt <= CNT_MAX) // R11
        else $error("user count above lane count");

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (user_cnt == $past(user_cnt)) || (user_cnt == $past(user_cnt) + 1'b1) ||
        (user_cnt == $past(user_cnt) - 1'b1)) // R8
        else $error("user count jumped");

    AST_RST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (phy_rst == (user_cnt == '0))) // R9
        else $error("reset does not match user count");

    AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err})) // R12
        else $error("more than one response bit");

    AST_WR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> ((cfg_data == DATA_SEL) &&
                    ((cfg_addr == ADDR_PLL) || (cfg_addr == ADDR_CLK)))) // R4
        else $error("illegal configuration write");

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && gnt_valid && !gnt_on && user_cnt == '0)
            |=> (user_cnt == '0 && phy_rst && $stable(lane_idle))) // R10
        else $error("power-off at zero changed state");

endmodule

// File: tb/phy_pwr_seq_test.sv
module phy_pwr_seq_test;

    localparam int NL = 4;
    localparam int T  = 200;
    localparam int P  = 8;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:0] on_req, off_req;
    logic          pll_locked, pll_out_pending;
    logic [NL-1:0] done, err, lane_idle;
    logic          phy_rst, cfg_wr;
    logic [5:0]    cfg_addr;
    logic [3:0]    cfg_data;
    logic [2:0]    user_cnt;

    int checks = 0;
    int fails  = 0;

    phy_pwr_seq #(.NUM_LANES(NL), .TIMEOUT_CYC(T), .POLL_CYC(P),
                  .CFG_AW(6), .CFG_DW(4)) uut (
        .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
        .pll_locked(pll_locked), .pll_out_pending(pll_out_pending),
        .done(done), .err(err), .phy_rst(phy_rst), .lane_idle(lane_idle),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_wr(cfg_wr),
        .user_cnt(user_cnt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; on_req = '0; off_req = '0;
        pll_locked = 1'b1; pll_out_pending = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // raise one request, wait for its answer, then drop it
    task automatic run_req(input int lane, input bit is_on, input int lock_at,
                           input bit kill, output int lat, output bit gd,
                           output bit ge, output int others, output int nwr,
                           output int a0, output int a1, output int d0,
                           output int d1, output int s_rst, output int s_addr,
                           output int s_idle);
        @(negedge clk);
        if (is_on) on_req[lane] = 1'b1; else off_req[lane] = 1'b1;
        lat = 0; gd = 0; ge = 0; others = 0; nwr = 0;
        a0 = 0; a1 = 0; d0 = 0; d1 = 0; s_rst = 0; s_addr = 0; s_idle = 0;
        while (!(gd || ge) && lat < 5000) begin
            @(negedge clk);
            lat++;
            if (lat == lock_at) pll_locked = 1'b1;
            if (lat == 4) begin
                s_rst = int'(phy_rst); s_addr = int'(cfg_addr); s_idle = int'(lane_idle);
            end
            if (cfg_wr) begin
                if (nwr == 0) begin a0 = int'(cfg_addr); d0 = int'(cfg_data); end
                else if (nwr == 1) begin a1 = int'(cfg_addr); d1 = int'(cfg_data); end
                nwr++;
                if (kill && cfg_addr == 6'h12) pll_locked = 1'b0;
            end
            gd = done[lane];
            ge = err[lane];
            others = others | int'((done | err) & ~(NL'(1) << lane));
        end
        on_req[lane] = 1'b0; off_req[lane] = 1'b0;
    endtask

    task automatic wait_resp(output int lat, output int d, output int e);
        lat = 0; d = 0; e = 0;
        while (d == 0 && e == 0 && lat < 5000) begin
            @(negedge clk);
            lat++;
            d = int'(done); e = int'(err);
        end
    endtask

    initial begin
        int lat, others, nwr, a0, a1, d0, d1, s_rst, s_addr, s_idle, dd, ee;
        bit gd, ge;
        int exp_idle;

        // sweep: every lane as the first user
        for (int first = 0; first < NL; first++) begin
            do_reset();
            chk("R1 reset phy_rst", int'(phy_rst), 1);
            chk("R1 reset idle", int'(lane_idle), 15);
            chk("R1 reset count", int'(user_cnt), 0);
            chk("R1 reset strobes", int'({done, err, cfg_wr}), 0);
            exp_idle = 15;

            run_req(first, 1, 0, 0, lat, gd, ge, others, nwr, a0, a1, d0, d1, s_rst, s_addr, s_idle);
            exp_idle = exp_idle & ~(1 << first);
            chk("R5 bring-up done", int'(gd), 1);
            chk("R5 bring-up latency", lat, 12);
            chk("R12 only requester pulses", others, 0);
            chk("R3 reset released at wait", s_rst, 0);
            chk("R3 address at wait", s_addr, 'h10);
            chk("R3 lane woken at wait", (s_idle >> first) & 1, 0);
            chk("R4 write count", nwr, 2);
            chk("R4 first write", a0 * 16 + d0, 'h10 * 16 + 8);
            chk("R4 second write", a1 * 16 + d1, 'h12 * 16 + 8);
            chk("R5 count after bring-up", int'(user_cnt), 1);
            chk("R5 final address", int'(cfg_addr), 'h10);

            for (int k = 1; k < NL; k++) begin
                int ln;
                ln = (first + k) % NL;
                run_req(ln, 1, 0, 0, lat, gd, ge, others, nwr, a0, a1, d0, d1, s_rst, s_addr, s_idle);
                exp_idle = exp_idle & ~(1 << ln);
                chk("R8 join done", int'(gd), 1);
                chk("R8 join latency", lat, 2);
                chk("R8 join writes", nwr, 0);
                chk("R8 join count", int'(user_cnt), k + 1);
                chk("R8 join idle", int'(lane_idle), exp_idle);
                chk("R12 join others", others, 0);
            end

            run_req(first, 1, 0, 0, lat, gd, ge, others, nwr, a0, a1, d0, d1, s_rst, s_addr, s_idle);
            chk("R11 saturated done", int'(gd), 1);
            chk("R11 saturated count", int'(user_cnt), NL);

            for (int j = 0; j < NL; j++) begin
                run_req(j, 0, 0, 0, lat, gd, ge, others, nwr, a0, a1, d0, d1, s_rst, s_addr, s_idle);
                exp_idle = exp_idle | (1 << j);
                chk("R9 leave done", int'(gd), 1);
                chk("R9 leave latency", lat, 2);
                chk("R9 leave count", int'(user_cnt), NL - 1 - j);
                chk("R9 reset only at zero", int'(phy_rst), (j == NL - 1) ? 1 : 0);
                chk("R9 leave idle", int'(lane_idle), exp_idle);
            end

            run_req((first + 1) % NL, 0, 0, 0, lat, gd, ge, others, nwr, a0, a1, d0, d1, s_rst, s_addr, s_idle);
            chk("R10 off at zero error", int'(ge), 1);
            chk("R10 off at zero latency", lat, 1);
            chk("R10 off at zero count", int'(user_cnt), 0);
            chk("R10 off at zero idle", int'(lane_idle), 15);
            chk("R10 off at zero reset", int'(phy_rst), 1);
        end

        // timeout in the first lock wait
        do_reset();
        pll_locked = 1'b0;
        run_req(2, 1, 0, 0, lat, gd, ge, others, nwr, a0, a1, d0, d1, s_rst, s_addr, s_idle);
        chk("R7 lock timeout error", int'(ge), 1);
        chk("R7 lock timeout latency", lat, T + 3);
        chk("R3 reset released during wait", s_rst, 0);
        chk("R7 rollback reset", int'(phy_rst), 1);
        chk("R7 rollback count", int'(user_cnt), 0);
        chk("R7 rollback idle", int'(lane_idle), 15);

        // timeout in the output-pending wait
        pll_locked = 1'b1; pll_out_pending = 1'b1;
        run_req(1, 1, 0, 0, lat, gd, ge, others, nwr, a0, a1, d0, d1, s_rst, s_addr, s_idle);
        chk("R7 pending timeout error", int'(ge), 1);
        chk("R7 pending timeout latency", lat, T + 3);
        chk("R7 pending timeout writes", nwr, 2);
        chk("R7 pending rollback count", int'(user_cnt), 0);

        // timeout in the relock wait
        pll_out_pending = 1'b0;
        run_req(3, 1, 0, 1, lat, gd, ge, others, nwr, a0, a1, d0, d1, s_rst, s_addr, s_idle);
        chk("R7 relock timeout error", int'(ge), 1);
        chk("R7 relock timeout latency", lat, T + 3);
        chk("R7 relock rollback reset", int'(phy_rst), 1);

        // late lock caught at the next poll point
        pll_locked = 1'b0;
        run_req(0, 1, 6, 0, lat, gd, ge, others, nwr, a0, a1, d0, d1, s_rst, s_addr, s_idle);
        chk("R6 late lock done", int'(gd), 1);
        chk("R6 late lock latency", lat, 12 + P);
        chk("R6 late lock count", int'(user_cnt), 1);

        // arbitration
        do_reset();
        @(negedge clk);
        on_req[2] = 1'b1; on_req[1] = 1'b1;
        wait_resp(lat, dd, ee);
        chk("R2 lowest lane first", dd, 2);
        on_req[1] = 1'b0;
        wait_resp(lat, dd, ee);
        chk("R2 second lane served", dd, 4);
        chk("R2 second lane latency", lat, 3);
        on_req[2] = 1'b0;
        @(negedge clk);
        on_req[3] = 1'b1; off_req[3] = 1'b1;
        wait_resp(lat, dd, ee);
        chk("R2 on before off", dd, 8);
        chk("R2 on before off count", int'(user_cnt), 3);
        on_req[3] = 1'b0;
        wait_resp(lat, dd, ee);
        chk("R2 off served next", dd, 8);
        chk("R2 off served count", int'(user_cnt), 2);
        chk("R2 off served idle", int'(lane_idle[3]), 1);
        off_req[3] = 1'b0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule